// File: doc/BRIEF.md
# Pixel-Doubled SVGA Framebuffer Scanout

This block produces an 800 x 600 video stream at a 40 MHz pixel clock from a small framebuffer of 100 x 75 pixels. Every stored pixel fills an 8 x 8 square of the screen. The block runs free-running horizontal and vertical counters. From them it derives the sync pulses and a data-enable. It also derives the framebuffer byte that lies under the beam. That byte is split into blue, green and red fields for an external DAC.

The framebuffer is an 8 KiB byte memory. A bus master writes it through a plain address, data and write-enable port. The same port returns the byte at the addressed offset one cycle later. The bus maps this window at 0x010000, so the port carries only the byte offset inside that window. Offsets 0 to 7499 hold pixels in row-major order. The bytes above 7499 are ordinary storage.

Top module: `svga_fb_scanout`

## Requirements
- R1: A line lasts 1056 clocks and a frame lasts 628 lines. `dataEnable` is high exactly for columns 0..799 of lines 0..599.
- R2: `hSyncOut` is high, active-high, for columns 840..967 of every line. Outside those columns it is low.
- R3: `vSyncOut` is high, active-high, for the whole of lines 601..604. Outside those lines it is low.
- R4: At column h of visible line v, the displayed byte is the framebuffer byte at offset (v/8)*100 + h/8, with integer division.
- R5: The displayed byte is split as follows: `blueOut` is bits [7:6], `greenOut` is bits [5:3] and `redOut` is bits [2:0].
- R6: Whenever `dataEnable` is low, `blueOut`, `greenOut` and `redOut` are all zero.
- R7: All outputs lag the counters by one register stage, and the colour stays aligned with the timing. On the first clock edge after reset is released, the outputs show column 0 of line 0.
- R8: While `rst` is high, the sync, enable and colour outputs are all zero. Releasing `rst` restarts the scan at the top-left pixel.
- R9: When `busWrEn` is high, `busWrData` is stored at offset `busAddr`. `busRdData` returns the byte at `busAddr` one clock later. This holds for every offset up to 8191, including those above the pixel area.
- R10: A bus write may hit the byte being scanned out in the same cycle. In that case the screen shows either the old byte or the new byte, and the scan never stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pixClk | input | 1 | 40 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 13 | Byte offset in the framebuffer window |
| busWrEn | input | 1 | Write strobe for the bus |
| busWrData | input | 8 | Byte to store |
| busRdData | output | 8 | Byte at the previous cycle's `busAddr` |
| hSyncOut | output | 1 | Horizontal sync, active high |
| vSyncOut | output | 1 | Vertical sync, active high |
| dataEnable | output | 1 | High during visible pixels |
| blueOut | output | 2 | Blue level |
| greenOut | output | 3 | Green level |
| redOut | output | 3 | Red level |

## Verification
A bus write and the scanout read can land on the same framebuffer byte in the same clock. To provoke this, the bench follows the beam position. For a stretch of cycles it writes a new value to exactly the offset the scanout fetches on the next edge. The bench also rewrites the whole pixel area while the picture is being drawn. The scoreboard keeps both the old and the new value for every fetch, and it accepts either one on screen. Every other field, including sync and enable timing, must match exactly.

// File: rtl/svga_fb_pkg.sv
package svga_fb_pkg;

  localparam int COORD_W = 8;

  typedef struct packed {
    logic               active;
    logic               hSync;
    logic               vSync;
    logic [COORD_W-1:0] col;
    logic [COORD_W-1:0] row;
  } scanStrobe_t;

endpackage

// File: rtl/svga_fb_ctrl.sv
module svga_fb_ctrl
  import svga_fb_pkg::*;
#(
  parameter int H_VIS       = 800,
  parameter int H_FP        = 40,
  parameter int H_SYNC      = 128,
  parameter int H_BP        = 88,
  parameter int V_VIS       = 600,
  parameter int V_FP        = 1,
  parameter int V_SYNC      = 4,
  parameter int V_BP        = 23,
  parameter int SCALE_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rst,
  output scanStrobe_t strobe
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS_END = HW'(H_VIS);
  localparam logic [HW-1:0] HS_START  = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END    = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_VIS_END = VW'(V_VIS);
  localparam logic [VW-1:0] VS_START  = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END    = VW'(V_VIS + V_FP + V_SYNC);

  logic [HW-1:0] hCnt;
  logic [VW-1:0] vCnt;
  logic lineEnd, frameEnd;

  assign lineEnd  = (hCnt == H_LAST);
  assign frameEnd = (vCnt == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.active = (hCnt < H_VIS_END) && (vCnt < V_VIS_END);
    strobe.hSync  = (hCnt >= HS_START) && (hCnt < HS_END);
    strobe.vSync  = (vCnt >= VS_START) && (vCnt < VS_END);
    strobe.col    = strobe.active ? COORD_W'(hCnt >> SCALE_SHIFT) : '0;
    strobe.row    = strobe.active ? COORD_W'(vCnt >> SCALE_SHIFT) : '0;
  end

  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (hCnt == H_LAST) |=> (hCnt == '0));

  assert_row_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (hCnt != H_LAST) |=> $stable(vCnt));

  assert_hsync_blank_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.hSync |-> !strobe.active);

  assert_vsync_line_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe.vSync) |-> (hCnt == '0));

endmodule

// File: rtl/svga_fb_datapath.sv
module svga_fb_datapath
  import svga_fb_pkg::*;
#(
  parameter int FB_W      = 100,
  parameter int FB_H      = 75,
  parameter int MEM_BYTES = 8192,
  parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobe_t       strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              hSyncOut,
  output logic              vSyncOut,
  output logic              dataEnable,
  output logic [1:0]        blueOut,
  output logic [2:0]        greenOut,
  output logic [2:0]        redOut
);

  localparam logic [7:0]        FB_W_BITS = 8'(FB_W);
  localparam logic [ADDR_W-1:0] PIX_LIMIT = ADDR_W'(FB_W * FB_H);

  logic [7:0]        mem [MEM_BYTES];
  logic [ADDR_W-1:0] scanAddr;
  logic [7:0]        pixRd;
  logic              deQ, hSyncQ, vSyncQ;

  // row * FB_W as a sum of shifted copies of the row, one per set bit
  always_comb begin
    scanAddr = '0;
    for (int i = 0; i < 8; i++) begin
      if (FB_W_BITS[i]) scanAddr = scanAddr + (ADDR_W'(strobe.row) << i);
    end
    scanAddr = scanAddr + ADDR_W'(strobe.col);
  end

  always_ff @(posedge clk) begin
    if (busWrEn) mem[busAddr] <= busWrData;
    pixRd     <= mem[scanAddr];
    busRdData <= mem[busAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deQ    <= 1'b0;
      hSyncQ <= 1'b0;
      vSyncQ <= 1'b0;
    end else begin
      deQ    <= strobe.active;
      hSyncQ <= strobe.hSync;
      vSyncQ <= strobe.vSync;
    end
  end

  assign dataEnable = deQ;
  assign hSyncOut   = hSyncQ;
  assign vSyncOut   = vSyncQ;
  assign blueOut    = deQ ? pixRd[7:6] : '0;
  assign greenOut   = deQ ? pixRd[5:3] : '0;
  assign redOut     = deQ ? pixRd[2:0] : '0;

  assert_scan_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.active |-> (scanAddr < PIX_LIMIT));

  assert_sync_dark_R6: assert property (@(posedge clk) disable iff (rst)
    (hSyncQ || vSyncQ) |-> ({blueOut, greenOut, redOut} == 8'h00));

endmodule

// File: rtl/svga_fb_scanout.sv
module svga_fb_scanout
  import svga_fb_pkg::*;
#(
  parameter int H_VIS       = 800,
  parameter int H_FP        = 40,
  parameter int H_SYNC      = 128,
  parameter int H_BP        = 88,
  parameter int V_VIS       = 600,
  parameter int V_FP        = 1,
  parameter int V_SYNC      = 4,
  parameter int V_BP        = 23,
  parameter int SCALE_SHIFT = 3,
  parameter int FB_W        = 100,
  parameter int FB_H        = 75,
  parameter int MEM_BYTES   = 8192,
  parameter int ADDR_W      = $clog2(MEM_BYTES)
) (
  input  logic              pixClk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              hSyncOut,
  output logic              vSyncOut,
  output logic              dataEnable,
  output logic [1:0]        blueOut,
  output logic [2:0]        greenOut,
  output logic [2:0]        redOut
);

  scanStrobe_t strobe;

  svga_fb_ctrl #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .SCALE_SHIFT(SCALE_SHIFT)
  ) ctrl_i (
    .clk(pixClk), .rst(rst), .strobe(strobe)
  );

  svga_fb_datapath #(
    .FB_W(FB_W), .FB_H(FB_H), .MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)
  ) dpath_i (
    .clk(pixClk), .rst(rst), .strobe(strobe),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .dataEnable(dataEnable),
    .blueOut(blueOut), .greenOut(greenOut), .redOut(redOut)
  );

endmodule

// File: tb/svga_fb_scanout_tb_top.sv
`timescale 1ns/1ps
module svga_fb_scanout_tb_top;

  // horizontal timing at full size, vertical shortened to four stored rows
  localparam int HV = 800, HF = 40, HS = 128, HB = 88, HT = HV + HF + HS + HB;
  localparam int VV = 32, VF = 1, VS = 4, VB = 3, VT = VV + VF + VS + VB;
  localparam int FBW = 100, FBH = 4, PIX = FBW * FBH;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        hSyncOut, vSyncOut, dataEnable;
  logic [1:0]  blueOut;
  logic [2:0]  greenOut, redOut;

  svga_fb_scanout #(
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .FB_H(FBH)
  ) dut_i (
    .pixClk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .hSyncOut(hSyncOut), .vSyncOut(vSyncOut), .dataEnable(dataEnable),
    .blueOut(blueOut), .greenOut(greenOut), .redOut(redOut)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic       de;
    logic       hs;
    logic       vs;
    logic [7:0] pOld;
    logic [7:0] pNew;
    bit         inRst;
  } item_t;

  item_t      sbQ[$];
  logic [7:0] modelMem [8192];
  int mH = 0, mV = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  function automatic logic [7:0] pat(int i, int k);
    return 8'(i * 37 + k * 91 + 11);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // expected-item producer: one item per clock edge
  always @(posedge clk) begin : model_p
    item_t e;
    int a;
    if (rst) begin
      e = '{de: 1'b0, hs: 1'b0, vs: 1'b0, pOld: 8'h00, pNew: 8'h00, inRst: 1'b1};
      mH = 0;
      mV = 0;
    end else begin
      e.inRst = 1'b0;
      e.de = (mH < HV) && (mV < VV);
      e.hs = (mH >= HV + HF) && (mH < HV + HF + HS);
      e.vs = (mV >= VV + VF) && (mV < VV + VF + VS);
      a = (mV / 8) * FBW + mH / 8;
      e.pOld = e.de ? modelMem[a] : 8'h00;
      e.pNew = (e.de && busWrEn && busAddr == 13'(a)) ? busWrData : e.pOld;
      if (mH == HT - 1) begin
        mH = 0;
        mV = (mV == VT - 1) ? 0 : mV + 1;
      end else begin
        mH++;
      end
    end
    sbQ.push_back(e);
    if (busWrEn) modelMem[busAddr] = busWrData;
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin : monitor_p
    item_t e;
    logic [7:0] col;
    string tagT, tagC;
    if (sbQ.size() > 0) begin
      e = sbQ.pop_front();
      col = {blueOut, greenOut, redOut};
      tagT = e.inRst ? "R8" : "R1";
      chk(dataEnable == e.de, tagT, "enable", int'(dataEnable), int'(e.de));
      chk(hSyncOut == e.hs, e.inRst ? "R8" : "R2", "hsync", int'(hSyncOut), int'(e.hs));
      chk(vSyncOut == e.vs, e.inRst ? "R8" : "R3", "vsync", int'(vSyncOut), int'(e.vs));
      if (e.inRst)              tagC = "R8";
      else if (!e.de)           tagC = "R6";
      else if (e.pOld != e.pNew) tagC = "R10";
      else                      tagC = "R4/R5";
      chk(col == e.pOld || col == e.pNew, tagC, "colour", int'(col), int'(e.pOld));
    end
  end

  task automatic busWrite(int a, logic [7:0] d);
    busAddr   = 13'(a);
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic readCheck(int a, logic [7:0] expv);
    busAddr = 13'(a);
    busWrEn = 1'b0;
    @(negedge clk);
    chk(busRdData == expv, "R9", "readback", int'(busRdData), int'(expv));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : drive
    for (int i = 0; i < 8192; i++) modelMem[i] = 8'h00;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < PIX; i++) busWrite(i, (i == 1) ? 8'h99 : pat(i, 0));
    busWrite(7500, 8'hC3);
    busWrite(8191, 8'h3C);
    readCheck(7500, 8'hC3);
    readCheck(8191, 8'h3C);
    readCheck(5, pat(5, 0));
    chk(dataEnable == 1'b0 && hSyncOut == 1'b0, "R8", "held in reset",
        int'({dataEnable, hSyncOut}), 0);

    rst = 1'b0;
    @(negedge clk);
    chk(dataEnable == 1'b1, "R7", "first pixel enable", int'(dataEnable), 1);
    chk({blueOut, greenOut, redOut} == pat(0, 0), "R7", "first pixel colour",
        int'({blueOut, greenOut, redOut}), int'(pat(0, 0)));
    repeat (8) @(negedge clk);
    chk(blueOut == 2'd2 && greenOut == 3'd3 && redOut == 3'd1, "R5", "field split of 0x99",
        int'({blueOut, greenOut, redOut}), 8'h99);

    // same-cycle collisions with the beam (R10)
    while (!(mH == 100 && mV == 9)) @(negedge clk);
    for (int k = 0; k < 24; k++) busWrite((mV / 8) * FBW + mH / 8, pat(k, 1));

    // repaint the pixel area while it is displayed (R4)
    for (int i = 0; i < PIX; i++) busWrite(i, pat(i, 2));
    readCheck(20, pat(20, 2));
    readCheck(7500, 8'hC3);

    repeat (HT * VT) @(negedge clk);

    // reset in mid-frame restarts at the top-left (R8)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dataEnable == 1'b1 && {blueOut, greenOut, redOut} == pat(0, 2), "R8",
        "restart at top-left", int'({blueOut, greenOut, redOut}), int'(pat(0, 2)));
    repeat (HT * 3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin : watchdog
    #950000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule